// File: doc/BRIEF.md
# Nibble-Serial GHASH Multiplier

This block multiplies a 128-bit value by a fixed hash key in GF(2^128) and keeps the running GHASH digest. It consumes one 4-bit digit of the operand per clock. A register file holds sixteen 128-bit key multiples, and software fills it through a write port before any blocks are sent. On each step the accumulator shifts right by four bit places. The four bits that leave the accumulator are folded back through a computed reduction term. The accumulator is then XORed with the key multiple that the current digit selects.

Blocks arrive on a valid/ready stream, and the block takes a block only while it is idle. In hash mode the digest is XORed with the incoming block and the result is multiplied by the key. In multiply mode the digest alone is multiplied, and the block data is unused. After 32 digit steps the product replaces the digest, and `done` pulses for one cycle. A clear input zeroes the digest between messages.

Top module: `ghash_nibble_mac`

## Requirements
- R1: `key_we` high while idle writes `key_entry` into entry `key_idx`. Entry i must hold the sum of H·x^0 if i[3] is set, H·x^1 if i[2] is set, H·x^2 if i[1] is set and H·x^3 if i[0] is set. Key writes made while a block is in progress are ignored.
- R2: The result equals the GCM-field product of operand and H. Bytes are big-endian, so `xi[127:120]` is byte 0 and its bit 7 is the x^0 coefficient. The field polynomial is x^128+x^7+x^2+x+1. Digits are used from byte 15 down to byte 0, low nibble first.
- R3: With `in_mode`=1 (hash), the new digest is (digest XOR `in_data`)·H.
- R4: With `in_mode`=0 (multiply), the new digest is digest·H, and `in_data` has no effect.
- R5: `done` is high for exactly one cycle, 32 clocks after the accepting edge. `xi` takes the new value in the same cycle.
- R6: `in_ready` is low from the accepting edge until `done`. `in_valid` is ignored while `in_ready` is low.
- R7: After synchronous reset, `xi` is zero, `in_ready` is 1 and `done` is 0.
- R8: `clr` zeroes the digest at every edge where it is high. It also takes priority over a result write-back. When `clr` is high at an accept, the operand is formed from a zero digest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Zero the digest |
| in_valid | input | 1 | Block offered |
| in_ready | output | 1 | Idle, block can be taken |
| in_data | input | 128 | Data block, byte 0 in bits 127:120 |
| in_mode | input | 1 | 1 = hash, 0 = multiply |
| key_we | input | 1 | Key table write strobe |
| key_idx | input | 4 | Key table entry index |
| key_entry | input | 128 | Key table entry value |
| done | output | 1 | One-cycle completion pulse |
| xi | output | 128 | Current digest |

## Verification
Clear can land in the same cycle as two other events. When it coincides with the accept of a block, the bench expects the product of the block alone, as if the digest were already zero. When it is asserted during the final digit step, it coincides with the write-back. The bench then expects `done` to pulse and the digest to read zero afterwards. Both cases are driven on purpose, and clear is also mixed at random into accepts. Every result is compared with a bit-serial field product computed in the bench.

// File: rtl/ghash_nib_pkg.sv
package ghash_nib_pkg;

    // Operation selected on the input stream
    typedef enum logic {
        MODE_MULT = 1'b0,
        MODE_HASH = 1'b1
    } op_mode_e;

    // Top byte of the reflected field polynomial term applied per dropped bit
    localparam logic [7:0] POLY_TOP_BYTE = 8'hE1;

endpackage

// File: rtl/ghash_key_table.sv
module ghash_key_table #(
    parameter int W = 128,
    parameter int D = 4
) (
    input  logic         clk,
    input  logic         wr_en,
    input  logic [D-1:0] wr_idx,
    input  logic [W-1:0] wr_val,
    input  logic [D-1:0] rd_idx,
    output logic [W-1:0] rd_val
);
    localparam int ENTRIES = 1 << D;

    logic [W-1:0] slot_q [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == D'(e))) begin
                slot_q[e] <= wr_val;
            end
        end
    end

    assign rd_val = slot_q[rd_idx];

endmodule

// File: rtl/ghash_digit_step.sv
module ghash_digit_step
    import ghash_nib_pkg::*;
#(
    parameter int W = 128,
    parameter int D = 4
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] entry,
    input  logic         first,
    output logic [W-1:0] acc_next
);
    localparam logic [W-1:0] POLY_TERM = {POLY_TOP_BYTE, {(W-8){1'b0}}};

    logic [W-1:0] fold_term [D];
    logic [W-1:0] fold_sum;

    // Bit k leaves after k+1 single shifts, then travels D-1-k more places
    for (genvar k = 0; k < D; k++) begin : g_fold
        assign fold_term[k] = acc[k] ? (POLY_TERM >> (D - 1 - k)) : '0;
    end

    always_comb begin
        fold_sum = '0;
        for (int k = 0; k < D; k++) begin
            fold_sum = fold_sum ^ fold_term[k];
        end
    end

    always_comb begin
        if (first) begin
            acc_next = entry;
        end else begin
            acc_next = (acc >> D) ^ fold_sum ^ entry;
        end
    end

endmodule

// File: rtl/ghash_nibble_mac.sv
module ghash_nibble_mac
    import ghash_nib_pkg::*;
#(
    parameter int W = 128,
    parameter int D = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    input  logic         in_mode,
    input  logic         key_we,
    input  logic [D-1:0] key_idx,
    input  logic [W-1:0] key_entry,
    output logic         done,
    output logic [W-1:0] xi
);
    localparam int STEPS = W / D;
    localparam int CNT_W = $clog2(STEPS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     opnd;
        logic [W-1:0]     acc;
        logic [W-1:0]     xi;
        logic             done;
    } state_t;

    state_t       st_q, st_d;
    logic [W-1:0] entry_val;
    logic [W-1:0] step_val;
    logic [W-1:0] base_val;
    logic         tbl_wr;

    assign tbl_wr = key_we && !st_q.busy;

    ghash_key_table #(.W(W), .D(D)) u_table (
        .clk    (clk),
        .wr_en  (tbl_wr),
        .wr_idx (key_idx),
        .wr_val (key_entry),
        .rd_idx (st_q.opnd[D-1:0]),
        .rd_val (entry_val)
    );

    ghash_digit_step #(.W(W), .D(D)) u_step (
        .acc      (st_q.acc),
        .entry    (entry_val),
        .first    (st_q.cnt == '0),
        .acc_next (step_val)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        base_val  = clr ? '0 : st_q.xi;
        if (clr) begin
            st_d.xi = '0;
        end
        if (!st_q.busy) begin
            if (in_valid) begin
                st_d.busy = 1'b1;
                st_d.cnt  = '0;
                if (op_mode_e'(in_mode) == MODE_HASH) begin
                    st_d.opnd = base_val ^ in_data;
                end else begin
                    st_d.opnd = base_val;
                end
            end
        end else begin
            st_d.acc  = step_val;
            st_d.opnd = st_q.opnd >> D;
            st_d.cnt  = st_q.cnt + CNT_W'(1);
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.cnt  = '0;
                if (!clr) begin
                    st_d.xi = step_val;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready = !st_q.busy;
    assign done     = st_q.done;
    assign xi       = st_q.xi;

    // R5: completion pulse lasts one cycle
    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5: idle again when the result appears
    a_r5_done_ready: assert property (@(posedge clk) disable iff (rst)
        done |-> in_ready);

    // R6: an accepted block makes the stream busy
    a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    // R6: no completion without having been busy
    a_r6_done_needs_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(!in_ready));

    // R8: clear always leaves a zero digest
    a_r8_clr_zero: assert property (@(posedge clk) disable iff (rst)
        clr |=> (xi == '0));

    // R7: reset state
    a_r7_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (xi == '0 && !done && in_ready));

    // R1: table writes while busy must not reach the table
    a_r1_table_locked: assert property (@(posedge clk) disable iff (rst)
        (!in_ready) |-> !tbl_wr);

endmodule

// File: tb/sim_ghash_nibble_mac.sv
module sim_ghash_nibble_mac;
    logic         clk = 1'b0;
    logic         rst;
    logic         clr;
    logic         in_valid;
    logic         in_ready;
    logic [127:0] in_data;
    logic         in_mode;
    logic         key_we;
    logic [3:0]   key_idx;
    logic [127:0] key_entry;
    logic         done;
    logic [127:0] xi;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;

    logic [127:0] cur_h;
    logic [127:0] model_xi;

    always #10 clk = ~clk;

    ghash_nibble_mac u0 (
        .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_mode(in_mode), .key_we(key_we), .key_idx(key_idx),
        .key_entry(key_entry), .done(done), .xi(xi)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog: run did not finish, actual=%0d expected<150000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [127:0] mulx(input logic [127:0] v);
        return (v >> 1) ^ (v[0] ? {8'hE1, 120'd0} : 128'd0);
    endfunction

    function automatic logic [127:0] gf_mul(input logic [127:0] a, input logic [127:0] h);
        logic [127:0] z = '0;
        logic [127:0] v = h;
        for (int i = 0; i < 128; i++) begin
            if (a[127 - i]) z = z ^ v;
            v = mulx(v);
        end
        return z;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R1: entry i = sum of H*x^(3-b) over set bits b of i
    task automatic load_key(input logic [127:0] h);
        logic [127:0] m [4];
        m[3] = h;
        m[2] = mulx(m[3]);
        m[1] = mulx(m[2]);
        m[0] = mulx(m[1]);
        for (int i = 0; i < 16; i++) begin
            logic [127:0] e = '0;
            for (int b = 0; b < 4; b++) if (i[b]) e = e ^ m[b];
            @(negedge clk);
            key_we    = 1'b1;
            key_idx   = 4'(i);
            key_entry = e;
        end
        @(negedge clk);
        key_we = 1'b0;
        cur_h  = h;
    endtask

    task automatic run_block(input logic [127:0] d, input bit mode, input bit c,
                             input bit disturb, input bit clr_end, input string req);
        logic [127:0] base = c ? 128'd0 : model_xi;
        logic [127:0] opnd = mode ? (base ^ d) : base;
        logic [127:0] exp  = gf_mul(opnd, cur_h);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_mode = mode; clr = c;
        @(negedge clk);
        in_valid = 1'b0; clr = 1'b0; in_data = rnd128();
        chk(!in_ready, "R6 ready low after accept", {127'd0, in_ready}, 128'd0);
        for (int i = 1; i <= 32; i++) begin
            if (i > 1) @(negedge clk);
            if (disturb && i == 4) begin
                in_valid = 1'b1; in_data = rnd128(); in_mode = ~mode;
                key_we = 1'b1; key_idx = 4'd5; key_entry = rnd128();
            end
            if (disturb && i == 6) begin
                in_valid = 1'b0; key_we = 1'b0;
            end
            if (i == 31) begin
                chk(!done, "R5 no early done", {127'd0, done}, 128'd0);
                if (clr_end) clr = 1'b1;
            end
        end
        @(negedge clk);
        clr = 1'b0;
        model_xi = clr_end ? 128'd0 : exp;
        chk(done, "R5 done at step 32", {127'd0, done}, 128'd1);
        chk(xi == model_xi, req, xi, model_xi);
        @(negedge clk);
        chk(!done, "R5 done single cycle", {127'd0, done}, 128'd0);
    endtask

    initial begin
        void'($urandom(32'h1F2E_3D4C));
        rst = 1'b1; clr = 1'b0; in_valid = 1'b0; in_data = '0; in_mode = 1'b0;
        key_we = 1'b0; key_idx = '0; key_entry = '0; model_xi = '0; cur_h = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(xi == '0, "R7 xi zero after reset", xi, 128'd0);
        chk(in_ready, "R7 ready after reset", {127'd0, in_ready}, 128'd1);
        chk(!done, "R7 done low after reset", {127'd0, done}, 128'd0);

        // R2: the multiplicative identity key returns the operand, byte 0 on top
        load_key({8'h80, 120'd0});
        run_block(128'h00112233_44556677_8899AABB_CCDDEEFF, 1'b1, 1'b0, 1'b0, 1'b0,
                  "R2 identity key keeps byte order");

        // R3 / R8: clear together with accept, then chained hash
        load_key(rnd128());
        run_block(rnd128(), 1'b1, 1'b1, 1'b0, 1'b0, "R8 clr at accept uses zero digest");
        run_block(rnd128(), 1'b1, 1'b0, 1'b0, 1'b0, "R3 chained hash block");

        // R4: multiply mode ignores data
        run_block(rnd128(), 1'b0, 1'b0, 1'b0, 1'b0, "R4 multiply mode ignores data");

        // R1 / R6: valid and key writes during a run are ignored
        run_block(128'h5555_5555_5555_5555_5555_5555_5555_5555, 1'b1, 1'b0, 1'b1, 1'b0,
                  "R1 R6 disturbance during run ignored");
        run_block(128'h5A5A_5A5A_5A5A_5A5A_A5A5_A5A5_A5A5_A5A5, 1'b1, 1'b0, 1'b0, 1'b0,
                  "R1 table intact after busy write");

        // R8: clear at the write-back edge wins
        run_block(rnd128(), 1'b1, 1'b0, 1'b0, 1'b1, "R8 clr beats write-back");

        // R8: clear while idle
        run_block(rnd128(), 1'b1, 1'b0, 1'b0, 1'b0, "R3 hash before idle clear");
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0; model_xi = '0;
        chk(xi == '0, "R8 idle clear", xi, 128'd0);

        // R2: all-ones operand and random stream
        run_block({128{1'b1}}, 1'b1, 1'b1, 1'b0, 1'b0, "R2 all-ones operand");
        load_key(rnd128());
        for (int n = 0; n < 24; n++) begin
            logic [3:0] sel = 4'($urandom);
            run_block(rnd128(), sel[0] | sel[1], sel == 4'd7, sel == 4'd9, 1'b0,
                      "R2 R3 R4 random block");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule